// File: doc/BRIEF.md
# Lane-Splittable 48-bit Add/Logic Unit

This unit takes two 48-bit operands and a carry-in. It returns either their arithmetic combination or a bitwise logic combination, registered one cycle later. A static lane mode sets how the adder's carry chain is cut. It can run as one 48-bit adder, as two independent 24-bit adders, or as four independent 12-bit adders. Each lane reports its own carry-out, so narrow data can be packed side by side in one wide word.

The operation code can change every cycle. When its top bit is set, the same operands pass through a bitwise logic stage and the adder's result is not used. All arithmetic is two's complement. Output registers have an asynchronous active-low reset, a synchronous clear and a clock enable.

Top module: `simd_alu48`

## Requirements
- R1: With `lane_mode_i` = 00 or 11, one lane is used. In add mode (`alu_op_i` = 0000, or any code with bit 3 low and bit 0 low), the result is `a_i + b_i + carry_i` modulo 2^48, and `carry_o[3]` is the carry out of bit 47.
- R2: With `lane_mode_i` = 01, bits [23:0] and [47:24] are added as separate lanes and no carry passes from bit 23 into bit 24. `carry_o[1]` is the carry out of the low lane and `carry_o[3]` is the carry out of the high lane.
- R3: With `lane_mode_i` = 10, each 12-bit field [12k+11:12k] is added as its own lane, and `carry_o[k]` is that lane's carry-out.
- R4: `carry_i` enters only the lowest lane. Upper lanes get no external carry in add mode and behave as if the borrow-in were zero in subtract mode.
- R5: With bit 3 low and bit 0 high (for example 0001), each lane computes `a - b`. The lowest lane also subtracts `carry_i` as a borrow. Each lane's carry bit is the carry of `a + ~b + cin`, so 1 means no borrow.
- R6: With bit 3 high, the result is bitwise: 1000 AND, 1001 OR, 1010 XOR, 1011 `a & ~b`, 1100 NAND, 1101 NOR, 1110 XNOR, 1111 `~a | b`. `carry_i` is ignored and `carry_o` is all zero.
- R7: `carry_o` bits that are not a lane's carry-out in the current mode read zero. In one-lane mode these are bits 2..0. In two-lane mode they are bits 0 and 2.
- R8: Outputs are registered with one cycle of latency. While `en_i` is low and `srst_i` is low, they hold their value.
- R9: `srst_i` high clears both outputs at the next clock edge and takes priority over `en_i`.
- R10: `rst_ni` low clears both outputs at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear |
| en_i | input | 1 | Clock enable for output registers |
| lane_mode_i | input | 2 | 00/11 one lane, 01 two lanes, 10 four lanes |
| alu_op_i | input | 4 | Operation code |
| a_i | input | 48 | Operand A |
| b_i | input | 48 | Operand B |
| carry_i | input | 1 | Carry-in (borrow when subtracting) to lowest lane |
| result_o | output | 48 | Registered result |
| carry_o | output | 4 | Registered per-lane carry-out |

## Verification
The bench sets lane fields to all ones and adds one, so every boundary produces a carry. A design that lets carry leak across a lane cut shows a non-zero bit just above the boundary, and the carry lands in the wrong `carry_o` bit. Subtracting with `carry_i` set checks that only the lowest lane takes the borrow. A design that feeds the borrow to every lane comes out one low in the upper lanes. It also runs every logic code, checks that the unused carry bits stay zero, and checks that the output holds or clears around enable and the synchronous clear.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam logic [1:0] MODE_ONE  = 2'b00;
  localparam logic [1:0] MODE_TWO  = 2'b01;
  localparam logic [1:0] MODE_FOUR = 2'b10;

  localparam logic [1:0] LOP_AND   = 2'b00;
  localparam logic [1:0] LOP_OR    = 2'b01;
  localparam logic [1:0] LOP_XOR   = 2'b10;
  localparam logic [1:0] LOP_ANDN  = 2'b11;
endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
  parameter int unsigned SEG_W = 12
) (
  input  logic [SEG_W-1:0] a_i,
  input  logic [SEG_W-1:0] b_i,
  input  logic             sub_i,
  input  logic             cin_i,
  output logic [SEG_W-1:0] sum_o,
  output logic             cout_o
);
  logic [SEG_W-1:0] b_eff;
  logic [SEG_W:0]   full;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{SEG_W{1'b0}}, cin_i};
  assign sum_o  = full[SEG_W-1:0];
  assign cout_o = full[SEG_W];
endmodule

// File: rtl/simd_logic_unit.sv
module simd_logic_unit
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 48
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] base;

  always_comb begin
    unique case (op_i[1:0])
      LOP_AND:  base = a_i & b_i;
      LOP_OR:   base = a_i | b_i;
      LOP_XOR:  base = a_i ^ b_i;
      default:  base = a_i & ~b_i;
    endcase
  end

  // op bit 2 selects the complemented family
  assign res_o = op_i[2] ? ~base : base;
endmodule

// File: rtl/simd_alu48.sv
module simd_alu48
  import simd_alu_pkg::*;
#(
  parameter int unsigned SEG_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                srst_i,
  input  logic                en_i,
  input  logic [1:0]          lane_mode_i,
  input  logic [3:0]          alu_op_i,
  input  logic [4*SEG_W-1:0]  a_i,
  input  logic [4*SEG_W-1:0]  b_i,
  input  logic                carry_i,
  output logic [4*SEG_W-1:0]  result_o,
  output logic [3:0]          carry_o
);
  localparam int unsigned NSEG   = 4;
  localparam int unsigned DATA_W = NSEG * SEG_W;

  logic              is_logic, is_sub, mode_two, mode_four;
  logic [NSEG-1:0]   seg_cin, seg_cout, seg_cut, cout_valid;
  logic [DATA_W-1:0] arith_res, logic_res, res_d;
  logic [NSEG-1:0]   cout_d;

  assign is_logic  = alu_op_i[3];
  assign is_sub    = alu_op_i[0];
  assign mode_two  = (lane_mode_i == MODE_TWO);
  assign mode_four = (lane_mode_i == MODE_FOUR);

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    // a cut below segment k starts a fresh lane
    if (k == 0) begin : g_low
      assign seg_cut[k] = 1'b1;
      assign seg_cin[k] = is_sub ? ~carry_i : carry_i;
    end else if (k == NSEG/2) begin : g_mid
      assign seg_cut[k] = mode_two | mode_four;
      assign seg_cin[k] = seg_cut[k] ? is_sub : seg_cout[k-1];
    end else begin : g_quarter
      assign seg_cut[k] = mode_four;
      assign seg_cin[k] = seg_cut[k] ? is_sub : seg_cout[k-1];
    end

    simd_seg_adder #(.SEG_W(SEG_W)) u_seg (
      .a_i    (a_i[k*SEG_W +: SEG_W]),
      .b_i    (b_i[k*SEG_W +: SEG_W]),
      .sub_i  (is_sub),
      .cin_i  (seg_cin[k]),
      .sum_o  (arith_res[k*SEG_W +: SEG_W]),
      .cout_o (seg_cout[k])
    );

    // carry of segment k is reported when segment k+1 starts a lane
    if (k == NSEG-1) begin : g_top
      assign cout_valid[k] = 1'b1;
    end else begin : g_inner
      assign cout_valid[k] = seg_cut[k+1];
    end
  end

  simd_logic_unit #(.DATA_W(DATA_W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (alu_op_i[2:0]),
    .res_o (logic_res)
  );

  assign res_d  = is_logic ? logic_res : arith_res;
  assign cout_d = is_logic ? '0 : (seg_cout & cout_valid);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= '0;
    end else if (srst_i) begin
      result_o <= '0;
      carry_o  <= '0;
    end else if (en_i) begin
      result_o <= res_d;
      carry_o  <= cout_d;
    end
  end

  assert_one_lane_cout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !srst_i && !alu_op_i[3] && (lane_mode_i == 2'b00 || lane_mode_i == 2'b11))
      |=> (carry_o[2:0] == 3'b000));

  assert_two_lane_cout_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !srst_i && lane_mode_i == MODE_TWO) |=> (!carry_o[0] && !carry_o[2]));

  assert_logic_no_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !srst_i && alu_op_i[3]) |=> (carry_o == 4'b0000));

  assert_sync_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (result_o == '0 && carry_o == '0));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !en_i) |=> ($stable(result_o) && $stable(carry_o)));
endmodule

// File: tb/simd_alu48_test.sv
module simd_alu48_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srst = 1'b0, en = 1'b0, cin = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [3:0]  op = 4'b0000;
  logic [47:0] a = '0, b = '0;
  logic [47:0] res;
  logic [3:0]  cout;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [51:0] exp_q = '0;
  logic [51:0] sb_exp[$];
  string       sb_tag[$];

  always #10 clk = ~clk;

  simd_alu48 uut (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .en_i(en),
    .lane_mode_i(mode), .alu_op_i(op), .a_i(a), .b_i(b), .carry_i(cin),
    .result_o(res), .carry_o(cout)
  );

  function automatic logic [51:0] model(input logic [1:0] m, input logic [3:0] o,
                                        input logic [47:0] x, input logic [47:0] y,
                                        input logic c);
    logic [47:0] r = '0;
    logic [3:0]  co = '0;
    int nl, w;
    if (o[3]) begin
      case (o)
        4'b1000: r = x & y;
        4'b1001: r = x | y;
        4'b1010: r = x ^ y;
        4'b1011: r = x & ~y;
        4'b1100: r = ~(x & y);
        4'b1101: r = ~(x | y);
        4'b1110: r = ~(x ^ y);
        default: r = ~x | y;
      endcase
      return {4'b0, r};
    end
    nl = (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
    w  = 48 / nl;
    for (int l = 0; l < nl; l++) begin
      logic [48:0] mask, xv, yv, s, ci;
      mask = (49'h1 << w) - 49'h1;
      xv = ({1'b0, x} >> (l*w)) & mask;
      yv = ({1'b0, y} >> (l*w)) & mask;
      if (o[0]) begin
        yv = ~yv & mask;
        ci = (l == 0) ? {48'b0, ~c} : 49'h1;
      end else begin
        ci = (l == 0) ? {48'b0, c} : 49'h0;
      end
      s = xv + yv + ci;
      r = r | 48'((s & mask) << (l*w));
      co[(l+1)*(4/nl)-1] = s[w];
    end
    return {co, r};
  endfunction

  task automatic drive(input logic s, input logic e, input logic [1:0] m,
                       input logic [3:0] o, input logic [47:0] x,
                       input logic [47:0] y, input logic c, input string tag);
    @(negedge clk);
    srst = s; en = e; mode = m; op = o; a = x; b = y; cin = c;
    if (s) exp_q = '0;
    else if (e) exp_q = model(m, o, x, y, c);
    sb_exp.push_back(exp_q);
    sb_tag.push_back(tag);
  endtask

  // monitor: checks each item 5 ns after the edge that captured it
  initial forever begin
    @(posedge clk);
    #5;
    if (sb_exp.size() > 0) begin
      logic [51:0] e;
      string t;
      e = sb_exp.pop_front();
      t = sb_tag.pop_front();
      n_tests++;
      if ({cout, res} !== e) begin
        n_fail++;
        $display("FAIL %s: got carry=%h res=%h expected carry=%h res=%h",
                 t, cout, res, e[51:48], e[47:0]);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #35;
    n_tests++;
    if (res !== '0 || cout !== '0) begin
      n_fail++;
      $display("FAIL R10: got res=%h carry=%h expected 0", res, cout);
    end
    rst_n = 1'b1;

    // R1 full-width carry ripple and carry-out
    drive(0, 1, 2'b00, 4'b0000, 48'hFFFF_FFFF_FFFF, 48'h0, 1'b1, "R1");
    drive(0, 1, 2'b11, 4'b0000, 48'h8000_0000_0001, 48'h8000_0000_0001, 1'b0, "R1");
    drive(0, 1, 2'b00, 4'b0010, 48'h0000_00FF_F000, 48'h0000_0000_1000, 1'b0, "R1");
    // R2 cut at bit 24
    drive(0, 1, 2'b01, 4'b0000, 48'hFFFFFF_FFFFFF, 48'h000000_000001, 1'b0, "R2");
    drive(0, 1, 2'b01, 4'b0000, 48'h7FFFFF_FFFFFF, 48'h000001_000000, 1'b1, "R2");
    // R3 cuts at 12/24/36
    drive(0, 1, 2'b10, 4'b0000, 48'hFFF_FFF_FFF_FFF, 48'h001_001_001_001, 1'b0, "R3");
    drive(0, 1, 2'b10, 4'b0000, 48'h800_7FF_FFF_000, 48'h800_001_000_FFF, 1'b1, "R3");
    // R4 carry-in only in lowest lane
    drive(0, 1, 2'b10, 4'b0000, 48'hFFF_FFF_FFF_FFE, 48'h0, 1'b1, "R4");
    drive(0, 1, 2'b01, 4'b0001, 48'h000005_000005, 48'h000002_000002, 1'b1, "R4");
    // R5 subtract with borrow
    drive(0, 1, 2'b00, 4'b0001, 48'h0, 48'h1, 1'b0, "R5");
    drive(0, 1, 2'b10, 4'b0001, 48'h005_000_010_003, 48'h003_001_010_004, 1'b1, "R5");
    drive(0, 1, 2'b01, 4'b0111, 48'h000000_000000, 48'h000000_000000, 1'b0, "R5");
    // R6 every logic code
    for (int k = 8; k < 16; k++)
      drive(0, 1, 2'b10, 4'(k), 48'hF0F0_CCCC_AAAA, 48'hFF00_AAAA_5555, 1'b1, "R6");
    // R7 masked carry bits
    drive(0, 1, 2'b00, 4'b0000, 48'hFFF_FFF_FFF_FFF, 48'h001_001_001_001, 1'b0, "R7");
    drive(0, 1, 2'b01, 4'b0000, 48'hFFF_FFF_FFF_FFF, 48'h001_001_001_001, 1'b0, "R7");
    // R8 hold with enable low
    drive(0, 0, 2'b10, 4'b0000, 48'h123_456_789_ABC, 48'h111_111_111_111, 1'b0, "R8");
    drive(0, 0, 2'b00, 4'b1001, 48'hFFFF_0000_FFFF, 48'h0, 1'b0, "R8");
    drive(0, 1, 2'b00, 4'b0000, 48'h1, 48'h2, 1'b0, "R8");
    // R9 sync clear beats enable
    drive(1, 1, 2'b00, 4'b0000, 48'hFFFF_FFFF_FFFF, 48'h1, 1'b1, "R9");
    drive(1, 0, 2'b00, 4'b0000, 48'h5, 48'h5, 1'b0, "R9");
    // mixed sweep across modes and ops
    for (int i = 0; i < 120; i++) begin
      logic [47:0] x, y;
      logic [3:0]  o;
      x = {$urandom(), $urandom()} >> 16;
      y = {$urandom(), $urandom()} >> 16;
      o = (i % 3 == 2) ? 4'(8 + i % 8) : 4'(i % 2);
      case (i % 4)
        0: drive(0, 1, 2'b00, o, x, y, 1'(i), "R1");
        1: drive(0, 1, 2'b01, o, x, y, 1'(i >> 1), "R2");
        2: drive(0, 1, 2'b10, o, x, y, 1'(i >> 2), "R3");
        default: drive(0, 1, 2'b11, o, x, y, 1'(i >> 1), "R7");
      endcase
    end
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    // R10 asynchronous clear mid-cycle
    #3 rst_n = 1'b0;
    #2;
    n_tests++;
    if (res !== '0 || cout !== '0) begin
      n_fail++;
      $display("FAIL R10: got res=%h carry=%h expected 0", res, cout);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule